// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible front end of a small LCD panel controller. Six 32-bit registers sit behind a simple synchronous bus port: control, three timing words, status and subpanel. The unit stores what software writes, masking some fields and keeping others whole. On readback it merges the stored fields with bits that always read as one. Line width and frame height are written as count minus one and held internally as the real count, which drives the pixel fetch logic.

Three status flags are held here: frame done, palette loaded and sync error. The frame fetch sequencer reports palette loads and sync errors through single-cycle event inputs. The frame done flag follows from the enable bit. Turning the controller on sends a start pulse, and turning it off sends a stop pulse. A pulse is sent only when the enable bit really changes value. The flags feed one registered, level-sensitive interrupt line. Frame done and palette loaded each have their own enable bit. A sync error always raises the line and cannot be masked.

Top module: `lcd_reg_unit`

## Requirements
- R1: Register offsets are control 0x00, timing0 0x04, timing1 0x08, timing2 0x0C, status 0x10 and subpanel 0x14. A read of any other offset returns zero, and a write to it changes nothing. Read data is registered and appears one cycle after the address.
- R2: A control write stores load mode from bits 21:20, panel type from bit 7, interrupt enables from bits 4:3, mono from bit 1 and enable from bit 0. It also keeps the bits selected by mask 0x01CFF300. A control read returns the panel type at bit 23 and at bit 7, the load mode at 21:20, the interrupt enables at 4:3, mono at 1, enable at 0 and the kept bits, all ORed with 0xFE000C34.
- R3: A timing0 write stores bits 31:10 as a timing field and bits 9:0 plus one as the line width, shown on `line_width`. A timing1 write does the same for the frame height, shown on `frame_height`. A read returns the timing field in bits 31:10 and the count minus one in bits 9:0. A timing0 read also ORs in 0x0000000F.
- R4: A timing2 write stores the full word, and a timing2 read returns it ORed with 0xFC000000.
- R5: A subpanel write stores the value ANDed with 0xA1FFFFFF, and a read returns the stored word.
- R6: A status read returns palette loaded at bit 6, sync error at bit 2 and frame done at bit 0, with all other bits zero. Writes to status are ignored.
- R7: A control write that changes the enable bit from 0 to 1 gives a one-cycle `start_pulse` and clears frame done and palette loaded. A write that leaves the enable bit unchanged gives no pulse.
- R8: A control write that changes the enable bit from 1 to 0 gives a one-cycle `stop_pulse` and clears sync error. It also sets frame done unless the load mode written is 1.
- R9: A `pal_evt` cycle sets palette loaded. A `sync_evt` cycle sets sync error and clears the enable bit, without a stop pulse.
- R10: `irq` is registered. One cycle after the flags settle it equals (frame done AND control bit 3) OR (palette loaded AND control bit 4) OR sync error.
- R11: Reset clears every stored field and flag. Width and height become zero, and `irq`, `start_pulse` and `stop_pulse` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered from the previous cycle's address |
| pal_evt | input | 1 | Palette load finished (from sequencer) |
| sync_evt | input | 1 | Sync error detected (from sequencer) |
| start_pulse | output | 1 | One-cycle request to start frame fetch |
| stop_pulse | output | 1 | One-cycle request to stop frame fetch |
| irq | output | 1 | Level interrupt |
| line_width | output | 11 | Pixels per line, 0 after reset |
| frame_height | output | 11 | Lines per frame, 0 after reset |

## Verification
The assertions check on every cycle that start and stop never occur together and that each pulse follows the enable state it leaves. They also check that a raised sync error leaves the controller disabled, that an unmapped read returns zero, and that the interrupt tracks the sync flag and falls when no flag is set. Only the bench scenarios can show the exact readback layouts and their constant bits, and the plus-one width and height over the whole 10-bit range. The same holds for the masked interrupt combinations and for the flag sequences through enable, disable and sequencer events.

// File: rtl/lcd_reg_unit.sv
module lcd_reg_unit #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          pal_evt,
  input  logic          sync_evt,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic          irq,
  output logic [10:0]   line_width,
  output logic [10:0]   frame_height
);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_T0   = AW'(8'h04);
  localparam logic [AW-1:0] A_T1   = AW'(8'h08);
  localparam logic [AW-1:0] A_T2   = AW'(8'h0C);
  localparam logic [AW-1:0] A_STAT = AW'(8'h10);
  localparam logic [AW-1:0] A_SUB  = AW'(8'h14);
  localparam logic [31:0] KEEP_MASK = 32'h01CF_F300;
  localparam logic [31:0] CTRL_ONES = 32'hFE00_0C34;
  localparam logic [31:0] SUB_MASK  = 32'hA1FF_FFFF;

  logic [1:0]  ld_mode, ie;
  logic        tft, mono, en;
  logic [31:0] keep_bits, t2_word, sub_word, rd_val;
  logic [21:0] t0_field, t1_field;
  logic        f_frame, f_pal, f_sync;

  wire wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  wire en_change = wr_ctrl && (bus_wdata[0] != en);
  wire turn_on   = en_change && bus_wdata[0];
  wire turn_off  = en_change && !bus_wdata[0];
  wire [10:0] w_m1 = line_width - 11'd1;
  wire [10:0] h_m1 = frame_height - 11'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_mode <= '0; ie <= '0; tft <= 1'b0; mono <= 1'b0; en <= 1'b0;
      keep_bits <= '0; t0_field <= '0; t1_field <= '0; t2_word <= '0;
      sub_word <= '0; line_width <= '0; frame_height <= '0;
      f_frame <= 1'b0; f_pal <= 1'b0; f_sync <= 1'b0;
      start_pulse <= 1'b0; stop_pulse <= 1'b0; irq <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ld_mode   <= bus_wdata[21:20];
        tft       <= bus_wdata[7];
        ie        <= bus_wdata[4:3];
        mono      <= bus_wdata[1];
        en        <= bus_wdata[0];
        keep_bits <= bus_wdata & KEEP_MASK;
      end
      if (bus_wr && bus_addr == A_T0) begin
        t0_field   <= bus_wdata[31:10];
        line_width <= {1'b0, bus_wdata[9:0]} + 11'd1;
      end
      if (bus_wr && bus_addr == A_T1) begin
        t1_field     <= bus_wdata[31:10];
        frame_height <= {1'b0, bus_wdata[9:0]} + 11'd1;
      end
      if (bus_wr && bus_addr == A_T2) t2_word <= bus_wdata;
      if (bus_wr && bus_addr == A_SUB) sub_word <= bus_wdata & SUB_MASK;

      start_pulse <= turn_on;
      stop_pulse  <= turn_off;
      if (turn_on) begin
        f_frame <= 1'b0;
        f_pal   <= 1'b0;
      end
      if (turn_off) begin
        f_sync <= 1'b0;
        if (bus_wdata[21:20] != 2'd1) f_frame <= 1'b1;
      end
      if (pal_evt) f_pal <= 1'b1;
      if (sync_evt) begin
        f_sync <= 1'b1;
        en     <= 1'b0;
      end

      irq       <= (f_frame && ie[0]) || (f_pal && ie[1]) || f_sync;
      bus_rdata <= rd_val;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL: rd_val = CTRL_ONES | keep_bits | {8'h00, tft, 1'b0, ld_mode, 12'h000,
                       tft, 2'b00, ie, 1'b0, mono, en};
      A_T0:   rd_val = {t0_field, w_m1[9:0]} | 32'h0000_000F;
      A_T1:   rd_val = {t1_field, h_m1[9:0]};
      A_T2:   rd_val = t2_word | 32'hFC00_0000;
      A_STAT: rd_val = {25'd0, f_pal, 3'b000, f_sync, 1'b0, f_frame};
      A_SUB:  rd_val = sub_word;
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/lcd_reg_unit_chk.sv
module lcd_reg_unit_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          start_pulse,
  input logic          stop_pulse,
  input logic          irq,
  input logic          en,
  input logic          f_frame,
  input logic          f_pal,
  input logic          f_sync
);
  wire mapped = bus_addr == AW'(8'h00) || bus_addr == AW'(8'h04) ||
                bus_addr == AW'(8'h08) || bus_addr == AW'(8'h0C) ||
                bus_addr == AW'(8'h10) || bus_addr == AW'(8'h14);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> bus_rdata == 32'd0); // R1
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse)); // R7
  AST_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(en)); // R7
  AST_STOP_FROM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> $past(en) && !en); // R8
  AST_SYNC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_sync) |-> !en); // R9
  AST_IRQ_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    f_sync |=> irq); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_frame && !f_pal && !f_sync) |=> !irq); // R10
endmodule

bind lcd_reg_unit lcd_reg_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse), .irq(irq),
  .en(en), .f_frame(f_frame), .f_pal(f_pal), .f_sync(f_sync)
);

// File: tb/lcd_reg_unit_test.sv
module lcd_reg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pal_evt = 1'b0, sync_evt = 1'b0;
  logic        start_pulse, stop_pulse, irq;
  logic [10:0] line_width, frame_height;

  int checks = 0, errors = 0;
  logic got_start, got_stop;
  logic [31:0] rv;

  always #10 clk = ~clk;

  lcd_reg_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    got_start = start_pulse; got_stop = stop_pulse;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    rv = bus_rdata;
  endtask

  task automatic evt(input logic p, input logic s);
    @(negedge clk);
    pal_evt = p; sync_evt = s;
    @(negedge clk);
    pal_evt = 1'b0; sync_evt = 1'b0;
    got_start = start_pulse; got_stop = stop_pulse;
  endtask

  function automatic logic [31:0] ctrl_exp(input logic [31:0] v);
    return 32'hFE000C34 | (v & 32'h01CFF300) | (v & 32'h0030_0000) |
           ({31'd0, v[7]} << 23) | (v & 32'h0000_009B);
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset values at the ports
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 width", {21'd0, line_width}, 32'd0);
    chk("R11 height", {21'd0, frame_height}, 32'd0);
    chk("R11 pulses", {30'd0, start_pulse, stop_pulse}, 32'd0);
    // R1 R11 full address sweep after reset
    for (int a = 0; a < 256; a++) begin
      rd(8'(a));
      case (a)
        8'h00: exp = 32'hFE000C34;
        8'h04: exp = 32'h000003FF;
        8'h08: exp = 32'h000003FF;
        8'h0C: exp = 32'hFC000000;
        default: exp = 32'h0;
      endcase
      chk("R1 R11 reset read", rv, exp);
    end
    // R1 writes to unmapped offsets change nothing
    for (int a = 1; a < 256; a += 5) if (a % 4 != 0 || a > 8'h14) wr(8'(a), 32'hFFFFFFFF);
    rd(8'h00); chk("R1 ctrl untouched", rv, 32'hFE000C34);
    rd(8'h14); chk("R1 sub untouched", rv, 32'h0);
    // R2 walking ones through control
    for (int i = 0; i < 32; i++) begin
      wr(8'h00, 32'd1 << i);
      rd(8'h00); chk("R2 ctrl walk", rv, ctrl_exp(32'd1 << i));
    end
    wr(8'h00, 32'hFFFFFFFE); rd(8'h00); chk("R2 ctrl all", rv, ctrl_exp(32'hFFFFFFFE));
    wr(8'h00, 32'h0010_0000);
    // R3 full sweep of the 10-bit counts
    for (int v = 0; v < 1024; v++) begin
      logic [31:0] d0, d1;
      d0 = (32'(v * 37 + 5) << 10) | 32'(v);
      d1 = (32'(v * 91 + 3) << 10) | 32'(1023 - v);
      wr(8'h04, d0);
      chk("R3 width", {21'd0, line_width}, 32'(v + 1));
      wr(8'h08, d1);
      chk("R3 height", {21'd0, frame_height}, 32'(1024 - v));
      if (v % 64 == 3) begin
        rd(8'h04); chk("R3 t0 read", rv, d0 | 32'hF);
        rd(8'h08); chk("R3 t1 read", rv, d1);
      end
    end
    // R4 R5
    foreach (rv[i]) begin end
    for (int k = 0; k < 8; k++) begin
      logic [31:0] p;
      p = 32'h9E37_79B9 * 32'(k + 1) ^ 32'(k << 28);
      wr(8'h0C, p); rd(8'h0C); chk("R4 t2", rv, p | 32'hFC000000);
      wr(8'h14, p); rd(8'h14); chk("R5 sub", rv, p & 32'hA1FFFFFF);
    end
    wr(8'h14, 32'hFFFFFFFF); rd(8'h14); chk("R5 sub ones", rv, 32'hA1FFFFFF);
    // R7 R8 R9 R6 flag sequence (ctrl currently load mode 1, disabled)
    wr(8'h00, 32'h0); chk("R8 no stop when unchanged", {31'd0, got_stop}, 32'd0);
    chk("R7 no start when unchanged", {31'd0, got_start}, 32'd0);
    wr(8'h00, 32'h1); chk("R7 start", {30'd0, got_start, got_stop}, 32'd2);
    wr(8'h00, 32'h1); chk("R7 repeat no pulse", {30'd0, got_start, got_stop}, 32'd0);
    rd(8'h10); chk("R7 flags cleared", rv, 32'h0);
    wr(8'h00, 32'h0); chk("R8 stop", {30'd0, got_start, got_stop}, 32'd1);
    rd(8'h10); chk("R8 frame done set", rv, 32'h1);
    wr(8'h00, 32'h1); rd(8'h10); chk("R7 frame cleared", rv, 32'h0);
    evt(1'b1, 1'b0); rd(8'h10); chk("R9 palette", rv, 32'h40);
    evt(1'b0, 1'b1); chk("R9 no stop on sync", {31'd0, got_stop}, 32'd0);
    rd(8'h10); chk("R9 sync", rv, 32'h44);
    rd(8'h00); chk("R9 enable cleared", rv & 32'h1, 32'h0);
    wr(8'h10, 32'hFFFFFFFF); rd(8'h10); chk("R6 status write ignored", rv, 32'h44);
    wr(8'h10, 32'h0); rd(8'h10); chk("R6 status zero write ignored", rv, 32'h44);
    wr(8'h00, 32'h0010_0001); rd(8'h10); chk("R7 clear keeps sync", rv, 32'h04);
    wr(8'h00, 32'h0010_0000); rd(8'h10); chk("R8 mode1 no frame, sync cleared", rv, 32'h0);
    // R10 sweep over enables and flag combinations
    for (int c = 0; c < 32; c++) begin
      logic [1:0] ien;
      logic ff, pf, sf;
      logic [31:0] iebits;
      ien = c[1:0]; ff = c[2]; pf = c[3]; sf = c[4];
      iebits = {27'd0, ien, 3'd0};
      wr(8'h00, 32'h0010_0001);
      wr(8'h00, 32'h0010_0000);
      if (ff) begin
        wr(8'h00, iebits | 32'h1);
        wr(8'h00, iebits);
      end else begin
        wr(8'h00, iebits | 32'h0010_0000);
      end
      if (pf) evt(1'b1, 1'b0);
      if (sf) evt(1'b0, 1'b1);
      @(negedge clk);
      chk("R10 irq", {31'd0, irq}, {31'd0, (ff & ien[0]) | (pf & ien[1]) | sf});
      rd(8'h10);
      chk("R6 status layout", rv, {25'd0, pf, 3'd0, sf, 1'b0, ff});
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule